// File: doc/BRIEF.md
# Grouped Programmable Input Debouncer

This block cleans up a bank of raw digital inputs, 32 by default, that arrive without any relation to the system clock. All channels share one programmable debounce time base. A channel's clean output takes a new level only when the raw input has held that level for a full acceptance window. Short pulses and contact bounce never reach the output.

A divider turns the fast system clock into a phase strobe every H = `div_wdata + 1` system cycles. Two strobes make one debounce clock period, so the debounce clock runs at f_clk / (2H). Each channel has a small counter that counts strobes while its synchronized input differs from its clean output. The counter restarts whenever the two agree. The output flips on the ninth strobe of an unbroken mismatch. The strobe phase has no relation to the moment the input changed, so a change is accepted after more than four and at most four and a half debounce clock periods. A new divider value is written into a holding register and takes over only at a strobe boundary.

Top module: `group_debounce`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `clean_out` is all zeros. The divider setting resets to 199, so H = 200 cycles, which is a 250 kHz debounce clock at 100 MHz.
- R2: Each raw input passes through two synchronizer flops. Suppose a new level is driven after clock edge 0 and then held. The clean output first shows it after clock edge k, where 8H+3 <= k <= 9H+2.
- R3: After reset with the default divider (H = 200), a held change is accepted after edge k, where 1603 <= k <= 1802.
- R4: Clean outputs change only on the cycle after a strobe. Channels whose inputs change at the same clock edge therefore all flip on the same cycle, and the bank never shows an intermediate mix of old and new levels.
- R5: A pulse that differs from the clean level for at most 8H consecutive cycles leaves the output unchanged.
- R6: If the input returns to the clean level before acceptance, the count is discarded. A later change again needs the full window of R2, measured from its own start.
- R7: Channels are independent. A change on one input never alters any other channel's output.
- R8: A pulse on `div_wr` stores `div_wdata` in a holding register. The active half-period switches to the held value only at a strobe boundary. A change already being counted keeps its progress and is still accepted. Once the new value is active, the window of R2 holds with the new H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | NCH (32) | Unsynchronized raw channel inputs |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W (17) | New divider setting; the strobe half-period is this value plus 1 |
| clean_out | output | NCH (32) | Debounced channel levels |

## Verification
Every result is due a number of cycles after its stimulus that depends on H. The synchronizer adds 2 cycles, the register stage adds 1, and acceptance takes 8 to 9 strobe intervals, which gives the window 8H+3 to 9H+2 edges from the drive. The bench drives inputs on falling edges and counts falling edges until the output settles. It then checks the count against the window for the active H, and it waits one old half-period after each divider write before relying on an exact window. Pulse and bounce cases are timed against the 8H bound. On every sampled cycle the bank is checked to hold either its old value or its new value.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    // Default parameter values shared by the debounce block.
    localparam int DBC_NCH       = 32;
    localparam int DBC_DIV_W     = 17;
    localparam int DBC_DIV_RST   = 199;
    localparam int DBC_STABLE    = 4;
    localparam int DBC_SYNC      = 2;

    // Strobes counted before acceptance: two per debounce period plus one
    // to absorb the unknown phase of the input change.
    function automatic int accept_strobes(input int stable_periods);
        return 2 * stable_periods + 1;
    endfunction
endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbc_tick_gen.sv
module dbc_tick_gen #(
    parameter int DIV_W   = 17,
    parameter int DIV_RST = 199
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] wdata_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] pend;
    } tick_st_t;

    tick_st_t st_d, st_q;

    assign strobe_o = (st_q.cnt == st_q.act);

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.pend = wdata_i;
        if (strobe_o) begin
            st_d.cnt = '0;
            st_d.act = st_q.pend;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.act  <= DIV_W'(DIV_RST);
            st_q.pend <= DIV_W'(DIV_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assert_act_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act != $past(st_q.act)) |-> $past(strobe_o));
    assert_cnt_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.act);
    assert_pend_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (st_q.pend == $past(wdata_i)));
endmodule

// File: rtl/dbc_channel.sv
module dbc_channel #(
    parameter int THRESH = 9,
    parameter int CNT_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic strobe_i,
    output logic level_o
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (strobe_i) begin
            if (st_q.cnt == CNT_W'(THRESH - 1)) begin
                st_d.lvl = sync_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;

    assert_flip_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> $past(strobe_i));
    assert_flip_needs_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> $past(sync_i != st_q.lvl));
    assert_match_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i == st_q.lvl) |=> (st_q.cnt == '0));
endmodule

// File: rtl/group_debounce.sv
module group_debounce
    import dbc_pkg::*;
#(
    parameter int NCH       = DBC_NCH,
    parameter int DIV_W     = DBC_DIV_W,
    parameter int DIV_RST   = DBC_DIV_RST,
    parameter int STABLE    = DBC_STABLE,
    parameter int SYNC_STGS = DBC_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   raw_in,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic [NCH-1:0]   clean_out
);
    localparam int THRESH = accept_strobes(STABLE);
    localparam int CNT_W  = $clog2(THRESH + 1);

    logic [NCH-1:0] sync_q;
    logic           strobe;

    dbc_sync #(.W(NCH), .STAGES(SYNC_STGS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_q)
    );

    dbc_tick_gen #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (div_wr),
        .wdata_i  (div_wdata),
        .strobe_o (strobe)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dbc_channel #(.THRESH(THRESH), .CNT_W(CNT_W)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_q[g]),
            .strobe_i (strobe),
            .level_o  (clean_out[g])
        );
    end
endmodule

// File: tb/group_debounce_tb_top.sv
module group_debounce_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_in = '0;
    logic        div_wr = 1'b0;
    logic [16:0] div_wdata = '0;
    logic [31:0] clean_out;

    int n_chk = 0;
    int n_fail = 0;
    int cur_h = 200;
    bit done = 1'b0;

    always #5 clk = ~clk;

    group_debounce dut_i (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
        .div_wr(div_wr), .div_wdata(div_wdata), .clean_out(clean_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_div(input int val);
        int old_h;
        old_h = cur_h;
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = 17'(val);
        @(negedge clk);
        div_wr = 1'b0;
        cur_h = val + 1;
        repeat (old_h + 4) @(negedge clk);
    endtask

    // Drive newv, count falling edges until clean_out equals it, check window.
    task automatic measure(input logic [31:0] newv, input int lo, input int hi,
                           input string req, input string mix_req);
        logic [31:0] oldv;
        int cnt;
        int bad;
        oldv = clean_out;
        cnt = 0;
        bad = 0;
        @(negedge clk);
        raw_in = newv;
        do begin
            @(negedge clk);
            cnt++;
            if (clean_out != oldv && clean_out != newv) bad++;
        end while (clean_out != newv && cnt < hi + 50);
        check(cnt >= lo && cnt <= hi, req, "acceptance edge count", cnt, lo);
        check(bad == 0, mix_req, "cycles with mixed old/new bank", bad, 0);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        check(clean_out == '0, "R1", "clean_out during reset", clean_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(clean_out == '0, "R1", "clean_out after reset", clean_out, 0);
    endtask

    task automatic t_default;
        // R3: default H = 200 -> window 1603..1802
        measure('1, 1603, 1802, "R3", "R4");
    endtask

    task automatic t_window;
        set_div(3);
        measure('0, 35, 38, "R2", "R4");
        measure(32'hA5A5_0F0F, 35, 38, "R2", "R4");
        // single-channel change, others must hold (R7)
        measure(32'hA5A5_0F8F, 35, 38, "R2", "R7");
    endtask

    task automatic t_glitch;
        logic [31:0] base;
        int changed;
        base = clean_out;
        changed = 0;
        @(negedge clk);
        raw_in = base ^ 32'h0000_0008;
        repeat (8 * cur_h) @(negedge clk);
        raw_in = base;
        repeat (8 * cur_h + 40) begin
            @(negedge clk);
            if (clean_out != base) changed++;
        end
        check(changed == 0, "R5", "cycles output moved on 8H pulse", changed, 0);
    endtask

    task automatic t_bounce;
        logic [31:0] base;
        logic [31:0] tgt;
        int moved;
        base = clean_out;
        tgt = base ^ 32'h00F0_0000;
        moved = 0;
        @(negedge clk);
        raw_in = tgt;
        repeat (20) begin
            @(negedge clk);
            if (clean_out != base) moved++;
        end
        raw_in = base;
        repeat (3) begin
            @(negedge clk);
            if (clean_out != base) moved++;
        end
        check(moved == 0, "R6", "output moved during bounce", moved, 0);
        measure(tgt, 35, 38, "R6", "R4");
    endtask

    task automatic t_prog;
        logic [31:0] tgt;
        int cnt;
        tgt = clean_out ^ 32'h0000_0100;
        cnt = 0;
        @(negedge clk);
        raw_in = tgt;
        div_wr = 1'b1;
        div_wdata = 17'd39;
        @(negedge clk);
        div_wr = 1'b0;
        cnt = 1;
        while (clean_out != tgt && cnt < 500) begin
            @(negedge clk);
            cnt++;
        end
        // R8: change in progress survives, new H=40 took over at the boundary
        check(cnt >= 320 && cnt <= 365, "R8", "edges with write mid-count", cnt, 323);
        cur_h = 40;
        repeat (44) @(negedge clk);
        measure(clean_out ^ 32'h8000_0001, 323, 362, "R8", "R4");
    endtask

    initial begin
        t_reset();
        t_default();
        t_window();
        t_glitch();
        t_bounce();
        t_prog();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule